// File: doc/BRIEF.md
# Square-Wave Flow-Control Signal Generator

This block sits on the receiving end of a serial link. It drives a single-bit back-channel signal that tells the transmitter whether it may keep sending. The signal is always a square wave, so it has no DC content and can pass through an AC-coupled differential pair. A fast wave, which toggles on every clock, means "ready". A slow wave, which holds each level for four clocks, means "busy".

The block watches the free-word count of the local receive FIFO. Busy is requested when the count is at or below a threshold (default 18 words). That margin covers the forward-path and return-path latency, so no word is lost after a stop is sent. The logic runs in the clock domain of the parallel SerDes interface. At 125 MHz, the ready wave is 62.5 MHz and the busy wave is 15.625 MHz.

A new state takes effect only where the current level ends. Every high or low run is therefore a whole run of the old rate or of the new rate. The transmitter, which measures run lengths, never sees a run that is truncated or stretched.

Top module: `fc_square_gen`

## Requirements
- R1: While the sampled free count is above THRESH (default 18), the output toggles on every clock edge, so each high and each low run lasts exactly one cycle.
- R2: While the sampled free count is at or below THRESH, each high and each low run lasts exactly SLOW_HALF (default 4) cycles.
- R3: A free count equal to THRESH (18) selects the 4-cycle pattern, and THRESH+1 (19) selects the 1-cycle pattern.
- R4: In either steady state, a high run and the low run that follows it have equal length, so the line stays DC free.
- R5: The free count is sampled only at the clock edge that ends a run, and that sample sets the length of the following run. A run already in progress always completes at its own length, and changes of the free count within a run have no effect.
- R6: While rst_n is low at a clock edge, the output is low after that edge. The first run after reset is a 4-cycle low run, whatever the free count is.
- R7: No run on the output is ever longer than SLOW_HALF cycles or shorter than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel SerDes interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| free_words | input | CNT_W ($clog2(FIFO_DEPTH+1), 7 by default) | Free 16-bit words in the receive FIFO |
| fc_out | output | 1 | Square-wave flow-control signal |

## Verification
The output level changes on the clock edge that ends a run. That same edge samples the free count, which governs the next run and not the one in progress. A free count applied between edges therefore first shows up in the run that starts at the next observed transition. The bench drives and samples on falling edges. It resynchronises on an observed transition before it measures any run, and it counts run lengths in whole sampled cycles from one transition to the next. The reset checks sample one falling edge after the reset edge, and time the first run from the falling edge that releases reset.

// File: rtl/fcg_pkg.sv
// Shared types for the square-wave flow-control generator.
// Assumes: one clock domain, no other package dependencies.
package fcg_pkg;

    // Signalling state carried by the back-channel wave.
    typedef enum logic {
        FC_READY = 1'b0,
        FC_BUSY  = 1'b1
    } fc_mode_e;

endpackage

// File: rtl/fcg_space_cmp.sv
// Free-space comparator: requests the busy state when the receive FIFO
// has THRESH or fewer free words.
// Assumes: free_words is stable in the clk domain; purely combinational.
module fcg_space_cmp #(
    parameter int FIFO_DEPTH = 64,
    parameter int THRESH     = 18,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic [CNT_W-1:0] free_words,
    output logic             busy_req
);

    generate
        if (THRESH >= FIFO_DEPTH) begin : g_always_busy
            // Threshold at or above capacity: the link can never run.
            assign busy_req = 1'b1;
        end else begin : g_compare
            localparam logic [CNT_W-1:0] THR = CNT_W'(THRESH);
            // Busy when free space is at or below the stop margin.
            assign busy_req = (free_words <= THR);
        end
    endgenerate

endmodule

// File: rtl/fcg_run_timer.sv
// Run timer: counts cycles within the current output level and flags the
// last cycle of a run, for the length chosen by the current mode.
// Assumes: mode changes only on the edge that ends a run; 1 <= FAST_HALF <= SLOW_HALF.
module fcg_run_timer
    import fcg_pkg::*;
#(
    parameter int SLOW_HALF = 4,
    parameter int FAST_HALF = 1,
    localparam int RUN_W    = $clog2(SLOW_HALF + 1)
) (
    input  logic     clk,
    input  logic     rst_n,
    input  fc_mode_e mode,
    output logic     end_of_run
);

    localparam logic [RUN_W-1:0] SLOW_LAST = RUN_W'(SLOW_HALF - 1);
    localparam logic [RUN_W-1:0] FAST_LAST = RUN_W'(FAST_HALF - 1);

    logic [RUN_W-1:0] run_cnt;
    logic [RUN_W-1:0] last_idx;

    // Select the final count index for the active rate.
    always_comb begin
        last_idx = (mode == FC_BUSY) ? SLOW_LAST : FAST_LAST;
    end

    assign end_of_run = (run_cnt == last_idx);

    // Advance within a run; restart at zero when the run ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (end_of_run) begin
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/fc_square_gen.sv
// Square-wave flow-control generator top: emits a fast square wave when the
// receive FIFO has room and a slow one when space is short. The mode is
// re-evaluated only at run boundaries, so every run is whole.
// Assumes: free_words is in the clk domain; synchronous active-low reset;
// after reset the busy pattern is shown for the first run.
module fc_square_gen
    import fcg_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int THRESH     = 18,
    parameter int SLOW_HALF  = 4,
    parameter int FAST_HALF  = 1,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] free_words,
    output logic             fc_out
);

    fc_mode_e mode_q;
    logic     wave_q;
    logic     busy_req;
    logic     end_of_run;

    fcg_space_cmp #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .THRESH     (THRESH)
    ) u_cmp (
        .free_words (free_words),
        .busy_req   (busy_req)
    );

    fcg_run_timer #(
        .SLOW_HALF  (SLOW_HALF),
        .FAST_HALF  (FAST_HALF)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_q),
        .end_of_run (end_of_run)
    );

    // Flip the line level and latch the next mode at the end of each run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= FC_BUSY;
            wave_q <= 1'b0;
        end else if (end_of_run) begin
            wave_q <= ~wave_q;
            mode_q <= busy_req ? FC_BUSY : FC_READY;
        end
    end

    assign fc_out = wave_q;

endmodule

// File: rtl/fc_square_gen_checker.sv
// Property checker for fc_square_gen, attached by bind. It watches the
// output run lengths, the mode register and the run-end strobe.
// Assumes: same parameters as the bound instance.
module fc_square_gen_checker #(
    parameter int FIFO_DEPTH = 64,
    parameter int THRESH     = 18,
    parameter int SLOW_HALF  = 4,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] free_words,
    input logic             fc_out,
    input logic             mode_busy,
    input logic             end_of_run
);

    localparam logic [CNT_W-1:0] THR = CNT_W'(THRESH);

    logic       prev_q;
    logic [7:0] len_q;

    // Track how many sampled cycles the output has held its level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            len_q  <= 8'd0;
        end else begin
            prev_q <= fc_out;
            len_q  <= (fc_out == prev_q) ? len_q + 8'd1 : 8'd1;
        end
    end

    assert_run_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
        len_q <= 8'(SLOW_HALF));

    assert_ready_toggle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_busy |=> fc_out != $past(fc_out));

    assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_busy && !end_of_run) |=> $stable(fc_out));

    assert_busy_thresh_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (end_of_run && free_words <= THR) |=> mode_busy);

    assert_ready_thresh_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (end_of_run && free_words > THR) |=> !mode_busy);

    assert_mode_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !end_of_run |=> $stable(mode_busy));

    assert_reset_state_R6: assert property (@(posedge clk)
        !rst_n |=> (fc_out == 1'b0 && mode_busy));

endmodule

bind fc_square_gen fc_square_gen_checker #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .THRESH     (THRESH),
    .SLOW_HALF  (SLOW_HALF)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .free_words (free_words),
    .fc_out     (fc_out),
    .mode_busy  (mode_q == fcg_pkg::FC_BUSY),
    .end_of_run (end_of_run)
);

// File: tb/fc_square_gen_tb.sv
// Self-checking bench for fc_square_gen: a table of free counts with expected
// run lengths, then directed reset and boundary-timing tests.
module fc_square_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] free_words = 7'd64;
    logic       fc_out;

    int checks = 0;
    int errs   = 0;
    int max_len = 0;
    bit done   = 1'b0;

    localparam int NV = 9;
    localparam int V_FREE[NV] = '{64, 18, 19, 0, 17, 40, 18, 64, 20};
    localparam int V_HALF[NV] = '{ 1,  4,  1, 4,  4,  1,  4,  1,  1};

    fc_square_gen u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .free_words (free_words),
        .fc_out     (fc_out)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count falling-edge samples from the current level up to the next change.
    task automatic next_toggle(output int len);
        logic start;
        start = fc_out;
        len = 0;
        do begin
            @(negedge clk);
            len++;
        end while (fc_out == start && len < 20);
        if (len > max_len) max_len = len;
    endtask

    initial begin
        int l0, l1, l2;
        string tag;
        // R6: output low while reset is held
        repeat (3) @(negedge clk);
        check("R6 reset level", int'(fc_out), 0);
        rst_n = 1'b1;
        next_toggle(l0);
        check("R6 first run busy", l0, 4);
        next_toggle(l0);
        check("R1 ready after first run", l0, 1);

        // Table walk: R1, R2, R3, R4
        for (int i = 0; i < NV; i++) begin
            free_words = 7'(V_FREE[i]);
            next_toggle(l0);
            next_toggle(l1);
            next_toggle(l2);
            if (V_FREE[i] == 18 || V_FREE[i] == 19) tag = "R3";
            else if (V_HALF[i] == 4) tag = "R2";
            else tag = "R1";
            check(tag, l1, V_HALF[i]);
            check(tag, l2, V_HALF[i]);
            check("R4 equal high and low", l1, l2);
        end

        // R5: ready to busy, current run keeps its old length
        free_words = 7'd5;
        next_toggle(l0);
        check("R5 ready run completes", l0, 1);
        next_toggle(l0);
        check("R5 busy follows", l0, 4);
        // R5: busy to ready, current busy run completes in full
        free_words = 7'd64;
        next_toggle(l0);
        check("R5 busy run completes", l0, 4);
        next_toggle(l0);
        check("R5 ready follows", l0, 1);
        // R5: changes within a run are ignored; only the boundary sample counts
        free_words = 7'd5;
        next_toggle(l0);
        @(negedge clk);
        free_words = 7'd64;
        @(negedge clk);
        free_words = 7'd5;
        next_toggle(l0);
        check("R5 run unaffected", l0, 2);
        next_toggle(l0);
        check("R5 mid-run glitch ignored", l0, 4);

        // R6: reset taken while the output is high
        free_words = 7'd64;
        next_toggle(l0);
        next_toggle(l0);
        while (fc_out != 1'b1) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R6 reset clears high level", int'(fc_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        next_toggle(l0);
        check("R6 busy run after reset", l0, 4);
        next_toggle(l0);
        check("R1 ready after reset", l0, 1);

        // R7: no run seen above four cycles
        check("R7 longest run", int'(max_len <= 4), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errs);
            $finish;
        end
    end

endmodule